// File: doc/BRIEF.md
# PCM Port Activity Power Controller

This block decides whether a two-channel PCM serial port is operating, saving power or powered down. It has no register interface: it watches the incoming bit clock and the transmit frame sync with a faster free-running system clock, and a bit clock or frame sync that stops toggling, whether stuck high or stuck low, drops the port into the power-saving state. An active-low power-down input takes priority over every other condition.

Both port signals pass through two-flop synchronizers before edges are detected. One idle timer per signal counts system clocks since that signal last changed. The frame period is measured between rising edges of the frame sync and compared with the window allowed for a 6 to 9 kHz frame rate. The port returns to operation only after two consecutive in-range frames. At that moment a single-cycle resync pulse tells the framers to realign. The output enable for the serial data outputs is high only while the port is operating. Out-of-range frames during operation set a sticky flag but do not change the state.

Top module: `pcm_activity_pwr_ctl`

## Requirements
- R1: After reset the state output is 1 (power-saving), and output enable, resync pulse and range flag are all 0.
- R2: When pd_n is 0 at a clock edge, the state output is 0 (power-down) after that edge, whatever the port signals do.
- R3: While operating, a bit clock held at either level for more than STALL_CYCLES system clocks moves the state to 1 (power-saving). A shorter hold leaves the state at 2.
- R4: While operating, a frame sync held at either level for more than STALL_CYCLES system clocks moves the state to 1 (power-saving).
- R5: dout_oe is 1 exactly when the state output is 2 (operating). It is 0 in power-saving and power-down.
- R6: From power-saving, the state becomes 2 only at the end of the second consecutive in-range frame with no stall in between. The first rising edge of frame sync after activity resumes serves only as the timing reference.
- R7: resync_o pulses high for exactly one cycle, in the same cycle the state output first reads 2 after power-saving, and at no other time.
- R8: A frame period is the number of system clocks between frame sync rising edges. It is in range when it lies in SYS_CLK_HZ/FS_MAX_HZ to SYS_CLK_HZ/FS_MIN_HZ. Two consecutive out-of-range periods set range_err_o, which stays set until reset. The state is not changed by this.
- R9: A single out-of-range period between in-range periods does not set range_err_o.
- R10: When pd_n returns to 1, the state output becomes 1 after the next edge, and R6 then governs the return to operating.
- R11: An out-of-range period while power-saving discards any in-range frame counted before it, so two further in-range frames are needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running system clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pd_n | input | 1 | Active-low power-down request, synchronous to clk |
| bclk_in | input | 1 | Port bit clock, asynchronous to clk |
| xsync_in | input | 1 | Port transmit frame sync, asynchronous to clk |
| state_o | output | 2 | 0 power-down, 1 power-saving, 2 operating |
| dout_oe | output | 1 | Output enable for the serial data outputs |
| resync_o | output | 1 | One-cycle pulse on return to operating |
| range_err_o | output | 1 | Sticky flag for two consecutive out-of-range frames |

## Verification
The hardest situation to reach is the restart after a bad frame while power-saving. It needs an out-of-range period to land exactly between the reference edge and the first good frame. The stimulus gets there by holding the port in power-down while one long frame is already latched into the frame generator, then releasing pd_n in the middle of that frame. Stalls at both levels of both signals are produced by freezing the generator for longer than the timeout. A cycle-accurate behavioural model checks every output on every clock.

// File: rtl/pcm_pwr_pkg.sv
// Shared state encoding for the PCM activity power controller.
// The numeric codes are visible on state_o and are part of the interface.
package pcm_pwr_pkg;
    typedef enum logic [1:0] {
        PWR_DOWN = 2'd0,
        PWR_SAVE = 2'd1,
        PWR_OPER = 2'd2
    } pwr_state_e;
endpackage

// File: rtl/bit_sync.sv
// Two-flop synchronizer with one extra history stage per bit.
// Assumes the inputs are asynchronous to clk and change slowly relative to it.
// cur_o is the synchronized level; prev_o is that level one clock earlier.
module bit_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] cur_q;
    logic [WIDTH-1:0] prev_q;

    // Capture, settle, and keep one stage of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= d_i;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur_o  = cur_q;
    assign prev_o = prev_q;
endmodule

// File: rtl/idle_timer.sv
// Counts system clocks since the watched signal last changed. It saturates
// at STALL_CYCLES and then reports a stall. Assumes edge_i is a one-cycle
// pulse per synchronized transition.
module idle_timer #(
    parameter int STALL_CYCLES = 166664
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    output logic stall_o
);
    localparam int W = $clog2(STALL_CYCLES + 1);

    logic [W-1:0] idle_q;

    assign stall_o = (idle_q >= W'(STALL_CYCLES));

    // Restart on every transition; otherwise count up to the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            idle_q <= '0;
        else if (edge_i)
            idle_q <= '0;
        else if (!stall_o)
            idle_q <= idle_q + 1'b1;
    end

    // R3
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_o && !edge_i) |=> stall_o);
endmodule

// File: rtl/frame_qual.sv
// Measures the frame-sync period in system clocks and grades each frame.
// Assumes rise_i pulses once per frame-sync rising edge and stall_i flags
// any stopped port signal. good_o is a combinational grade of the frame
// that ends this cycle. primed_o means one good frame is already counted.
module frame_qual #(
    parameter int FRAME_MIN = 27777,
    parameter int FRAME_MAX = 41666
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic stall_i,
    input  logic clear_i,
    output logic good_o,
    output logic primed_o,
    output logic range_err_o
);
    localparam int CW = $clog2(FRAME_MAX + 2);

    logic [CW-1:0] frm_q;
    logic          ref_q;
    logic          primed_q;
    logic          bad_q;
    logic          err_q;
    logic          in_rng;
    logic          bad;

    assign in_rng = (frm_q >= CW'(FRAME_MIN)) && (frm_q <= CW'(FRAME_MAX));
    assign good_o = rise_i && ref_q && in_rng && !stall_i;
    assign bad    = rise_i && ref_q && !in_rng && !stall_i;

    // Period counter: restarts at each rising edge, saturates past the window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            frm_q <= '0;
        else if (rise_i)
            frm_q <= CW'(1);
        else if (frm_q <= CW'(FRAME_MAX))
            frm_q <= frm_q + 1'b1;
    end

    // A timing reference exists once an edge has been seen since the last stall.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_q <= 1'b0;
        else if (stall_i)
            ref_q <= 1'b0;
        else if (rise_i)
            ref_q <= 1'b1;
    end

    // Run of good frames: any stall, hold-off or bad frame discards it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            primed_q <= 1'b0;
        else if (stall_i || clear_i || bad)
            primed_q <= 1'b0;
        else if (good_o)
            primed_q <= 1'b1;
    end

    // Memory of a preceding bad frame, and the sticky range flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bad_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (stall_i || good_o)
                bad_q <= 1'b0;
            else if (bad)
                bad_q <= 1'b1;
            if (bad && bad_q)
                err_q <= 1'b1;
        end
    end

    assign primed_o    = primed_q;
    assign range_err_o = err_q;

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
endmodule

// File: rtl/pcm_activity_pwr_ctl.sv
// Activity-driven power state controller for a two-channel PCM port.
// Watches the bit clock and transmit frame sync with the system clock. It
// drops to power-saving when either one stops, and to power-down when pd_n
// is low. It returns to operating after two good frames and then issues a
// one-cycle resync pulse. Assumes pd_n is already synchronous to clk.
module pcm_activity_pwr_ctl
    import pcm_pwr_pkg::*;
#(
    parameter int SYS_CLK_HZ   = 250_000_000,
    parameter int FS_MIN_HZ    = 6000,
    parameter int FS_MAX_HZ    = 9000,
    parameter int STALL_CYCLES = 4 * (SYS_CLK_HZ / FS_MIN_HZ)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pd_n,
    input  logic       bclk_in,
    input  logic       xsync_in,
    output logic [1:0] state_o,
    output logic       dout_oe,
    output logic       resync_o,
    output logic       range_err_o
);
    localparam int FRAME_MIN = SYS_CLK_HZ / FS_MAX_HZ;
    localparam int FRAME_MAX = SYS_CLK_HZ / FS_MIN_HZ;
    localparam int NSIG      = 2;

    logic [NSIG-1:0] s_cur;
    logic [NSIG-1:0] s_prev;
    logic [NSIG-1:0] s_edge;
    logic [NSIG-1:0] s_stall;
    logic            any_stall;
    logic            x_rise;
    logic            f_good;
    logic            f_primed;
    pwr_state_e      state_q, state_d;
    logic            resync_q, resync_d;

    bit_sync #(.WIDTH(NSIG)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_i    ({xsync_in, bclk_in}),
        .cur_o  (s_cur),
        .prev_o (s_prev)
    );

    assign s_edge = s_cur ^ s_prev;
    assign x_rise = s_cur[1] & ~s_prev[1];

    // One idle timer per watched signal: bit 0 bit clock, bit 1 frame sync.
    for (genvar gi = 0; gi < NSIG; gi++) begin : g_idle
        idle_timer #(.STALL_CYCLES(STALL_CYCLES)) u_idle (
            .clk     (clk),
            .rst_n   (rst_n),
            .edge_i  (s_edge[gi]),
            .stall_o (s_stall[gi])
        );
    end

    assign any_stall = |s_stall;

    frame_qual #(.FRAME_MIN(FRAME_MIN), .FRAME_MAX(FRAME_MAX)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .rise_i      (x_rise),
        .stall_i     (any_stall),
        .clear_i     (!pd_n),
        .good_o      (f_good),
        .primed_o    (f_primed),
        .range_err_o (range_err_o)
    );

    // Next-state decision; power-down request wins over everything.
    always_comb begin
        state_d  = state_q;
        resync_d = 1'b0;
        if (!pd_n) begin
            state_d = PWR_DOWN;
        end else begin
            case (state_q)
                PWR_DOWN: state_d = PWR_SAVE;
                PWR_OPER: if (any_stall) state_d = PWR_SAVE;
                PWR_SAVE: if (f_good && f_primed) begin
                    state_d  = PWR_OPER;
                    resync_d = 1'b1;
                end
                default:  state_d = PWR_SAVE;
            endcase
        end
    end

    // State and resync registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= PWR_SAVE;
            resync_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            resync_q <= resync_d;
        end
    end

    assign state_o  = state_q;
    assign dout_oe  = (state_q == PWR_OPER);
    assign resync_o = resync_q;

    // R2
    pd_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_n |=> (state_q == PWR_DOWN));
    // R3 R4
    stall_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_OPER && any_stall && pd_n) |=> (state_q == PWR_SAVE));
    // R6
    two_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PWR_SAVE && !(f_good && f_primed)) |=> (state_q != PWR_OPER));
    // R7
    resync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync_q |=> !resync_q);
    // R7
    resync_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync_q |-> (state_q == PWR_OPER && $past(state_q) == PWR_SAVE));
endmodule

// File: tb/tb_pcm_activity_pwr_ctl.sv
`timescale 1ns/1ps
module tb_pcm_activity_pwr_ctl;
    localparam int SYS   = 1_000_000;
    localparam int FMIN  = SYS / 9000;
    localparam int FMAX  = SYS / 6000;
    localparam int STALL = 4 * FMAX;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_n = 1'b1;
    logic       bclk_in = 1'b0;
    logic       xsync_in = 1'b0;
    logic [1:0] state_o;
    logic       dout_oe, resync_o, range_err_o;

    int n_chk = 0;
    int n_fail = 0;
    int resync_seen = 0;
    bit done = 1'b0;

    // stimulus controls
    bit b_run = 0, b_hold = 0, x_run = 0, x_hold = 0;
    int frame_len = 128;
    int frames = 0;

    always #2 clk = ~clk;

    pcm_activity_pwr_ctl #(
        .SYS_CLK_HZ(SYS), .FS_MIN_HZ(6000), .FS_MAX_HZ(9000), .STALL_CYCLES(STALL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .bclk_in(bclk_in), .xsync_in(xsync_in),
        .state_o(state_o), .dout_oe(dout_oe), .resync_o(resync_o), .range_err_o(range_err_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_frames(input int n);
        int target;
        target = frames + n;
        while (frames < target) @(negedge clk);
    endtask

    // port signal generator: bit clock period 4 system clocks, sync 4 clocks wide
    initial begin
        int bdiv = 0;
        int fcnt = 1 << 20;
        int cur_len = 128;
        forever begin
            @(negedge clk);
            if (b_run) begin
                bdiv++;
                if (bdiv >= 2) begin bdiv = 0; bclk_in = ~bclk_in; end
            end else bclk_in = b_hold;
            if (x_run) begin
                if (fcnt >= cur_len - 1) begin
                    fcnt = 0; cur_len = frame_len; frames++;
                end else fcnt++;
                xsync_in = (fcnt < 4);
            end else begin
                fcnt = 1 << 20;
                xsync_in = x_hold;
            end
        end
    end

    // behavioural reference model
    int hb[$] = '{0, 0, 0};
    int hx[$] = '{0, 0, 0};
    int m_bidle = 0, m_xidle = 0, m_frm = 0, m_state = 1;
    bit m_ref = 0, m_primed = 0, m_badlast = 0, m_err = 0, m_resync = 0;

    always @(posedge clk) begin : model
        bit b_e, x_e, x_r, st, in_rng, good, bad;
        if (!rst_n) begin
            hb = '{0, 0, 0}; hx = '{0, 0, 0};
            m_bidle = 0; m_xidle = 0; m_frm = 0; m_state = 1;
            m_ref = 0; m_primed = 0; m_badlast = 0; m_err = 0; m_resync = 0;
        end else begin
            b_e = (hb[1] != hb[2]);
            x_e = (hx[1] != hx[2]);
            x_r = (hx[1] == 1) && (hx[2] == 0);
            hb.push_front(int'(bclk_in)); void'(hb.pop_back());
            hx.push_front(int'(xsync_in)); void'(hx.pop_back());
            st = (m_bidle >= STALL) || (m_xidle >= STALL);
            in_rng = (m_frm >= FMIN) && (m_frm <= FMAX);
            good = x_r && m_ref && in_rng && !st;
            bad  = x_r && m_ref && !in_rng && !st;
            m_resync = 0;
            if (!pd_n) m_state = 0;
            else if (m_state == 0) m_state = 1;
            else if (m_state == 2 && st) m_state = 1;
            else if (m_state == 1 && good && m_primed) begin m_state = 2; m_resync = 1; end
            if (st || !pd_n || bad) m_primed = 0; else if (good) m_primed = 1;
            if (bad && m_badlast) m_err = 1;
            if (st || good) m_badlast = 0; else if (bad) m_badlast = 1;
            m_ref = st ? 1'b0 : (x_r ? 1'b1 : m_ref);
            m_frm = x_r ? 1 : ((m_frm <= FMAX) ? m_frm + 1 : m_frm);
            m_bidle = b_e ? 0 : ((m_bidle >= STALL) ? m_bidle : m_bidle + 1);
            m_xidle = x_e ? 0 : ((m_xidle >= STALL) ? m_xidle : m_xidle + 1);
        end
    end

    // every-cycle comparison against the model
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && !done) begin
                chk(int'(state_o) == m_state, "R2/R3/R4/R6/R10/R11", "state", state_o, m_state);
                chk(dout_oe == (m_state == 2), "R5", "dout_oe", dout_oe, int'(m_state == 2));
                chk(resync_o == m_resync, "R7", "resync", resync_o, m_resync);
                chk(range_err_o == m_err, "R8/R9", "range_err", range_err_o, m_err);
                if (resync_o) resync_seen++;
            end
        end
    end

    task automatic stall_case(input bit on_x, input bit lvl, input string req);
        if (on_x) begin x_hold = lvl; x_run = 0; end
        else begin b_hold = lvl; b_run = 0; end
        repeat (STALL - 64) @(negedge clk);
        chk(state_o == 2'd2, req, "still operating before timeout", state_o, 2);
        repeat (90) @(negedge clk);
        chk(state_o == 2'd1, req, "power-saving after static signal", state_o, 1);
        chk(dout_oe == 1'b0, "R5", "oe while saving", dout_oe, 0);
        if (on_x) x_run = 1; else b_run = 1;
        wait_frames(5);
        repeat (10) @(negedge clk);
        chk(state_o == 2'd2, "R6", "operating after resume", state_o, 2);
    endtask

    initial begin
        int r0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        chk(state_o == 2'd1, "R1", "reset state", state_o, 1);
        chk(dout_oe == 1'b0, "R1", "reset oe", dout_oe, 0);
        chk(resync_o == 1'b0, "R1", "reset resync", resync_o, 0);
        chk(range_err_o == 1'b0, "R1", "reset flag", range_err_o, 0);

        // R6 startup: reference edge plus two good frames
        b_run = 1; x_run = 1;
        wait_frames(2);
        repeat (10) @(negedge clk);
        chk(state_o == 2'd1, "R6", "saving after one good frame", state_o, 1);
        wait_frames(1);
        repeat (10) @(negedge clk);
        chk(state_o == 2'd2, "R6", "operating after two good frames", state_o, 2);
        chk(dout_oe == 1'b1, "R5", "oe while operating", dout_oe, 1);
        chk(resync_seen == 1, "R7", "resync pulse count", resync_seen, 1);

        // R3 and R4 at both levels
        stall_case(0, 1, "R3");
        stall_case(0, 0, "R3");
        stall_case(1, 0, "R4");
        stall_case(1, 1, "R4");
        chk(resync_seen == 5, "R7", "one pulse per return", resync_seen, 5);

        // R2 power-down forcing, R10 release, R11 bad frame while saving
        pd_n = 0;
        @(negedge clk);
        chk(state_o == 2'd0, "R2", "power-down state", state_o, 0);
        chk(dout_oe == 1'b0, "R2", "oe in power-down", dout_oe, 0);
        wait_frames(1);
        frame_len = 180;
        wait_frames(1);
        frame_len = 128;
        repeat (20) @(negedge clk);
        chk(state_o == 2'd0, "R2", "held in power-down with clocks running", state_o, 0);
        pd_n = 1;
        @(negedge clk);
        chk(state_o == 2'd1, "R10", "saving after release", state_o, 1);
        wait_frames(2);
        repeat (10) @(negedge clk);
        chk(state_o == 2'd1, "R11", "bad frame restarted the count", state_o, 1);
        wait_frames(1);
        repeat (10) @(negedge clk);
        chk(state_o == 2'd2, "R11", "operating after two more good frames", state_o, 2);
        chk(range_err_o == 1'b0, "R9", "single long frame no flag", range_err_o, 0);

        // R9 single short frame while operating
        wait_frames(1);
        frame_len = 100;
        wait_frames(1);
        frame_len = 128;
        wait_frames(3);
        repeat (10) @(negedge clk);
        chk(range_err_o == 1'b0, "R9", "single short frame no flag", range_err_o, 0);

        // R8 two consecutive short frames: flag set, state kept
        wait_frames(1);
        frame_len = 100;
        wait_frames(2);
        frame_len = 128;
        wait_frames(2);
        repeat (10) @(negedge clk);
        chk(range_err_o == 1'b1, "R8", "flag after two short frames", range_err_o, 1);
        chk(state_o == 2'd2, "R8", "state unchanged by range error", state_o, 2);
        wait_frames(3);
        chk(range_err_o == 1'b1, "R8", "flag sticky", range_err_o, 1);

        // R2 override during a stall
        r0 = resync_seen;
        b_run = 0;
        pd_n = 0;
        @(negedge clk);
        chk(state_o == 2'd0, "R2", "power-down with bit clock stopped", state_o, 0);
        chk(resync_seen == r0, "R7", "no pulse on power-down", resync_seen, r0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule